// File: doc/BRIEF.md
# Single-Cycle 16-Bit Processor Core

This block is a compact processor core. It runs one 16-bit instruction per clock, fetched from a separate instruction memory. It has sixteen 16-bit general registers, a data memory port and two condition flags, zero and negative.

Every instruction word holds the following fields:

- Two condition bits, which make the instruction conditional on the flags.
- A return bit, which pops a small call stack after the instruction.
- A loop-end bit, which closes a counted hardware loop.
- A class bit, which selects a register operation or a control operation.

Control operations are:

- A call to an 8-word-aligned target.
- A counted loop start.
- A short forward skip.
- A load-immediate, which takes the next instruction word as data.

The core is used with two memories that return read data in the same cycle as the address. The instruction memory is read at the program counter. The data memory is read and written at the address held in the register selected by the A field. Both memory ports are plain, with no handshake. The core never stalls and expects a read in the same cycle and a write at the clock edge.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, the flags, the call stack pointer, the loop counter and the pending load-immediate state are cleared, so `imem_addr` reads 0 after that edge.
- R2: The instruction word is laid out as follows: [15:12] is register B, [11:8] is register A, [7:5] is op, [4] is the class bit c, [3] is return r, [2] is loop-end x, [1] is n and [0] is z. With c=0, the register ops are: op 0 does B ^= A, op 2 does B = A, op 4 does B -= A and op 5 does B += A.
- R3: The remaining register ops, all with c=0, are as follows.
  - Op 1 adds the A field to B, read as a signed 4-bit value.
  - Op 3 with A=0 inverts B.
  - Op 3 with A nonzero shifts B. The A field is read as a signed amount: a positive value shifts logically right and a negative value shifts left by its magnitude.
- R4: With c=0, op 6 loads B from data memory at address reg[A]. Op 7 writes reg[B] to data memory at address reg[A], drives `dmem_we` for that one cycle and changes no register.
- R5: The register ops 0 to 5 set the zero flag to (result == 0) and the negative flag to result bit 15. Loads and stores leave both flags unchanged. An instruction with z=n=0 always executes. Otherwise it executes only if its z and n bits equal the zero and negative flags, and when skipped it has no effect at all.
- R6: An instruction with c=1 and r=0 is a call. It pushes PC+1 onto an 8-entry stack and jumps to {instr[15:5], 3'b000}. An executed c=0 instruction with r=1 performs its own operation, then jumps to the popped return address.
- R7: With c=1, r=1 and op 1, the instruction is a skip: the next PC is PC + instr[15:8] + 1, with instr[15:8] unsigned.
- R8: With c=1, r=1 and op 2, the instruction is a load-immediate. The next instruction word is written into register B and is never executed, and the instruction after that word is fetched next. The pair takes two cycles.
- R9: With c=1, r=1 and op 0, the instruction starts a loop. The count is loaded from reg[B] and the loop start is set to PC+1. An executed c=0 instruction with x=1 and a nonzero count decrements the count, and branches to the loop start if the count was above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 14 | Instruction memory word address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 14 | Data memory word address, taken from reg[A] |
| dmem_wdata | output | 16 | Store data, taken from reg[B] |
| dmem_rdata | input | 16 | Data memory word at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Data memory write enable, written at the rising edge |

## Verification
Register contents are visible only through stores, so a wrong result, a wrong flag or a wrong sequencer state shows up as a store with a bad address or value. It can also show up as a store that should not happen, or a store that never comes. Most faults are seen within a few cycles, at the next store of the affected register.

The programs are written so that each mistaken control decision produces a store that the test does not expect:

- A skipped path that is wrongly executed.
- A data word that is executed as an instruction.
- A conditional store that is taken wrongly.

Reset faults show directly on `imem_addr` in the first cycle after the reset edge.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned RSEL_W = 4;
  localparam int unsigned NREG   = 16;

  typedef enum logic [2:0] {
    OP_XOR   = 3'd0,
    OP_ADDI  = 3'd1,
    OP_COPY  = 3'd2,
    OP_SHNOT = 3'd3,
    OP_SUB   = 3'd4,
    OP_ADD   = 3'd5,
    OP_LOAD  = 3'd6,
    OP_STORE = 3'd7
  } reg_op_e;

  typedef enum logic [2:0] {
    CT_LOOP = 3'd0,
    CT_SKIP = 3'd1,
    CT_LDI  = 3'd2
  } ctl_op_e;

  typedef enum logic [2:0] {
    K_NONE, K_ALU, K_LOAD, K_STORE, K_CALL, K_LOOP, K_SKIP, K_LDI
  } kind_e;

  typedef struct packed {
    logic [RSEL_W-1:0] rb;
    logic [RSEL_W-1:0] ra;
    logic [2:0]        op;
    logic              c;
    logic              r;
    logic              x;
    logic              n;
    logic              z;
  } instr_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  input  logic              bubble_i,
  input  logic              flag_z_i,
  input  logic              flag_n_i,
  output logic              exec_o,
  output kind_e             kind_o,
  output logic [2:0]        op_o,
  output logic [RSEL_W-1:0] ra_o,
  output logic [RSEL_W-1:0] rb_o,
  output logic              ret_o,
  output logic              loop_end_o
);
  instr_t ins;
  assign ins = instr_t'(instr_i);
  assign op_o = ins.op;
  assign ra_o = ins.ra;
  assign rb_o = ins.rb;

  always_comb begin
    exec_o = !bubble_i &&
             ((!ins.z && !ins.n) || (ins.z == flag_z_i && ins.n == flag_n_i));
    kind_o = K_NONE;
    if (!ins.c) begin
      case (ins.op)
        OP_LOAD:  kind_o = K_LOAD;
        OP_STORE: kind_o = K_STORE;
        default:  kind_o = K_ALU;
      endcase
    end else if (!ins.r) begin
      kind_o = K_CALL;
    end else begin
      case (ins.op)
        CT_LOOP: kind_o = K_LOOP;
        CT_SKIP: kind_o = K_SKIP;
        CT_LDI:  kind_o = K_LDI;
        default: kind_o = K_NONE;
      endcase
    end
    if (!exec_o) kind_o = K_NONE;
    ret_o      = exec_o && !ins.c && ins.r;
    loop_end_o = exec_o && !ins.c && ins.x;
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [RSEL_W-1:0] ra_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] res_o
);
  logic [WORD_W-1:0] imm_ext;
  logic [RSEL_W-1:0] lsh;

  assign imm_ext = {{(WORD_W-RSEL_W){ra_i[RSEL_W-1]}}, ra_i};
  assign lsh     = (~ra_i) + RSEL_W'(1);

  always_comb begin
    case (op_i)
      OP_XOR:   res_o = b_i ^ a_i;
      OP_ADDI:  res_o = b_i + imm_ext;
      OP_COPY:  res_o = a_i;
      OP_SHNOT: begin
        if (ra_i == '0)               res_o = ~b_i;
        else if (!ra_i[RSEL_W-1])     res_o = b_i >> ra_i;
        else                          res_o = b_i << lsh;
      end
      OP_SUB:   res_o = b_i - a_i;
      OP_ADD:   res_o = b_i + a_i;
      default:  res_o = b_i;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16,
  localparam int unsigned SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ra_i,
  input  logic [SEL_W-1:0] rb_i,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [W-1:0]     wdata_i
);
  logic [W-1:0] regs_q [N];

  assign a_o = regs_q[ra_i];
  assign b_o = regs_q[rb_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(N); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wsel_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
  import cpu_pkg::*;
#(
  parameter int unsigned PC_W  = 14,
  parameter int unsigned STK_D = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned SP_W = (STK_D > 1) ? $clog2(STK_D) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  kind_e             kind_i,
  input  logic              ret_i,
  input  logic              loop_end_i,
  input  logic [10:0]       imm_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              ldi_pend_o,
  output logic [RSEL_W-1:0] ldi_dst_o
);
  logic [PC_W-1:0]   pc_q, pc_n, pc_inc, call_tgt, skip_tgt, loop_top_q, loop_top_n;
  logic [PC_W-1:0]   stk_q [STK_D];
  logic [SP_W-1:0]   sp_q, sp_n, sp_dec;
  logic [CNT_W-1:0]  loop_cnt_q, loop_cnt_n;
  logic              ldi_pend_q, ldi_pend_n, push;
  logic [RSEL_W-1:0] ldi_dst_q, ldi_dst_n;

  assign pc_inc   = pc_q + PC_W'(1);
  assign call_tgt = PC_W'({imm_i, 3'b000});
  assign skip_tgt = pc_q + PC_W'(imm_i[10:3]) + PC_W'(1);
  assign sp_dec   = sp_q - SP_W'(1);

  always_comb begin
    pc_n       = pc_inc;
    sp_n       = sp_q;
    push       = 1'b0;
    loop_cnt_n = loop_cnt_q;
    loop_top_n = loop_top_q;
    ldi_pend_n = 1'b0;
    ldi_dst_n  = ldi_dst_q;
    case (kind_i)
      K_CALL: begin pc_n = call_tgt; push = 1'b1; sp_n = sp_q + SP_W'(1); end
      K_SKIP: pc_n = skip_tgt;
      K_LDI:  begin ldi_pend_n = 1'b1; ldi_dst_n = imm_i[10:7]; end
      K_LOOP: begin loop_cnt_n = cnt_i; loop_top_n = pc_inc; end
      default: ;
    endcase
    if (ret_i) begin
      pc_n = stk_q[sp_dec];
      sp_n = sp_dec;
    end else if (loop_end_i && loop_cnt_q != '0) begin
      loop_cnt_n = loop_cnt_q - CNT_W'(1);
      if (loop_cnt_q > CNT_W'(1)) pc_n = loop_top_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      sp_q       <= '0;
      loop_cnt_q <= '0;
      loop_top_q <= '0;
      ldi_pend_q <= 1'b0;
      ldi_dst_q  <= '0;
    end else begin
      pc_q       <= pc_n;
      sp_q       <= sp_n;
      loop_cnt_q <= loop_cnt_n;
      loop_top_q <= loop_top_n;
      ldi_pend_q <= ldi_pend_n;
      ldi_dst_q  <= ldi_dst_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk_q[sp_q] <= pc_inc;
  end

  assign pc_o       = pc_q;
  assign ldi_pend_o = ldi_pend_q;
  assign ldi_dst_o  = ldi_dst_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && sp_q == '0 && loop_cnt_q == '0 && !ldi_pend_q));
  // R6
  call_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == K_CALL) |=> (pc_q == $past(call_tgt) && sp_q == $past(sp_q) + SP_W'(1)));
  // R6
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> (sp_q == $past(sp_dec)));
  // R7
  skip_target_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == K_SKIP) |=> (pc_q == $past(pc_q) + PC_W'($past(imm_i[10:3])) + PC_W'(1)));
  // R8
  ldi_single_chk: assert property (@(posedge clk) disable iff (rst)
    ldi_pend_q |=> !ldi_pend_q);
  // R9
  loop_load_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == K_LOOP) |=> (loop_cnt_q == $past(cnt_i)));
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned STK_D  = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_data,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [WORD_W-1:0] dmem_wdata,
  input  logic [WORD_W-1:0] dmem_rdata,
  output logic              dmem_we
);
  logic              flag_z_q, flag_n_q, exec, ret, loop_end, ldi_pend, wr_en;
  kind_e             kind;
  logic [2:0]        op;
  logic [RSEL_W-1:0] ra, rb, ldi_dst, wr_sel;
  logic [WORD_W-1:0] a_val, b_val, alu_res, wr_data;

  cpu_decode u_dec (
    .instr_i(imem_data), .bubble_i(ldi_pend), .flag_z_i(flag_z_q), .flag_n_i(flag_n_q),
    .exec_o(exec), .kind_o(kind), .op_o(op), .ra_o(ra), .rb_o(rb),
    .ret_o(ret), .loop_end_o(loop_end)
  );

  cpu_regfile #(.N(NREG), .W(WORD_W)) u_rf (
    .clk(clk), .rst(rst), .ra_i(ra), .rb_i(rb), .a_o(a_val), .b_o(b_val),
    .we_i(wr_en), .wsel_i(wr_sel), .wdata_i(wr_data)
  );

  cpu_alu u_alu (.op_i(op), .ra_i(ra), .a_i(a_val), .b_i(b_val), .res_o(alu_res));

  cpu_seq #(.PC_W(ADDR_W), .STK_D(STK_D), .CNT_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .kind_i(kind), .ret_i(ret), .loop_end_i(loop_end),
    .imm_i(imem_data[15:5]), .cnt_i(b_val), .pc_o(imem_addr),
    .ldi_pend_o(ldi_pend), .ldi_dst_o(ldi_dst)
  );

  assign wr_en   = ldi_pend || kind == K_ALU || kind == K_LOAD;
  assign wr_sel  = ldi_pend ? ldi_dst : rb;
  assign wr_data = ldi_pend ? imem_data : (kind == K_LOAD ? dmem_rdata : alu_res);

  assign dmem_we    = (kind == K_STORE);
  assign dmem_addr  = a_val[ADDR_W-1:0];
  assign dmem_wdata = b_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z_q <= 1'b0;
      flag_n_q <= 1'b0;
    end else if (kind == K_ALU) begin
      flag_z_q <= (alu_res == '0);
      flag_n_q <= alu_res[WORD_W-1];
    end
  end

  // R4
  store_no_regwrite_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, dmem_we}));
  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (kind != K_ALU) |=> ($stable(flag_z_q) && $stable(flag_n_q)));
  // R8
  ldi_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    ldi_pend |-> (!dmem_we && !exec));
endmodule

// File: tb/cpu_core_bench.sv
`timescale 1ns/1ps
module cpu_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] imem_addr, dmem_addr;
  logic [15:0] imem_data, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [15:0] imem [1024];
  logic [15:0] dmem [256];
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 1'b0;

  logic [13:0] exp_addr_q [$];
  logic [15:0] exp_data_q [$];
  string       exp_tag_q  [$];

  always #4 clk = ~clk;

  cpu_core u_cpu_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we)
  );

  assign imem_data  = imem[imem_addr[9:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

  // word = {B, A, op, c, r, x, n, z}
  function automatic logic [15:0] e_reg(input logic [2:0] op, input logic [3:0] a,
      input logic [3:0] b, input logic [1:0] nz, input logic x, input logic r);
    return {b, a, op, 1'b0, r, x, nz};
  endfunction
  function automatic logic [15:0] e_ctl(input logic [2:0] op, input logic [3:0] a,
      input logic [3:0] b);
    return {b, a, op, 5'b11000};
  endfunction
  function automatic logic [15:0] e_call(input logic [10:0] imm);
    return {imm, 5'b10000};
  endfunction
  function automatic logic [15:0] e_skip(input logic [7:0] imm);
    return e_ctl(3'd1, imm[3:0], imm[7:4]);
  endfunction

  task automatic put(input int addr, input logic [15:0] w);
    imem[addr] = w;
  endtask
  task automatic ldi(input int addr, input logic [3:0] rd, input logic [15:0] v);
    imem[addr]     = e_ctl(3'd2, 4'd0, rd);
    imem[addr + 1] = v;
  endtask
  task automatic clear_imem();
    for (int i = 0; i < 1024; i++) imem[i] = 16'h0000;
  endtask

  task automatic expect_store(input logic [13:0] a, input logic [15:0] d, input string tag);
    exp_addr_q.push_back(a);
    exp_data_q.push_back(d);
    exp_tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
      input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each store against the scoreboard
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R5/R7/R8 unexpected store", {dmem_addr, dmem_wdata}, 32'h0);
      end else begin
        logic [13:0] ea;
        logic [15:0] ed;
        string       et;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        et = exp_tag_q.pop_front();
        check(dmem_addr == ea && dmem_wdata == ed, et, {dmem_addr, dmem_wdata}, {ea, ed});
      end
    end
  end

  task automatic reset_and_run(input string name);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: PC back to zero after the reset edge
    check(imem_addr == 14'd0, {"R1 reset pc ", name}, 32'(imem_addr), 32'd0);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    check(exp_addr_q.size() == 0, {"R2 all stores seen ", name}, exp_addr_q.size(), 0);
    while (exp_addr_q.size() != 0) begin
      void'(exp_addr_q.pop_front());
      void'(exp_data_q.pop_front());
      void'(exp_tag_q.pop_front());
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // program 1: register ops, load/store, skip
    clear_imem();
    ldi(0, 4'd1, 16'h0010);
    ldi(2, 4'd2, 16'h1234);
    ldi(4, 4'd3, 16'h0F0F);
    put(6,  e_reg(3'd5, 4'd3, 4'd2, 2'b00, 0, 0)); // add
    put(7,  e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0));
    put(8,  e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(9,  e_reg(3'd4, 4'd3, 4'd2, 2'b00, 0, 0)); // sub
    put(10, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0));
    put(11, e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(12, e_reg(3'd0, 4'd3, 4'd2, 2'b00, 0, 0)); // xor
    put(13, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0));
    put(14, e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(15, e_reg(3'd2, 4'd3, 4'd4, 2'b00, 0, 0)); // copy
    put(16, e_reg(3'd3, 4'd0, 4'd4, 2'b00, 0, 0)); // not
    put(17, e_reg(3'd7, 4'd1, 4'd4, 2'b00, 0, 0));
    put(18, e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(19, e_reg(3'd3, 4'd4, 4'd4, 2'b00, 0, 0)); // shift right 4
    put(20, e_reg(3'd7, 4'd1, 4'd4, 2'b00, 0, 0));
    put(21, e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(22, e_reg(3'd3, 4'hC, 4'd4, 2'b00, 0, 0)); // shift left 4
    put(23, e_reg(3'd7, 4'd1, 4'd4, 2'b00, 0, 0));
    put(24, e_reg(3'd1, 4'hF, 4'd1, 2'b00, 0, 0)); // addi -1
    put(25, e_reg(3'd6, 4'd1, 4'd5, 2'b00, 0, 0)); // load
    put(26, e_reg(3'd1, 4'd4, 4'd1, 2'b00, 0, 0));
    put(27, e_reg(3'd7, 4'd1, 4'd5, 2'b00, 0, 0));
    put(28, e_skip(8'd3));
    put(29, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0)); // must be skipped
    put(30, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0));
    put(31, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0));
    put(32, e_call(11'd4));                        // halt
    expect_store(14'd16, 16'h2143, "R2 add");
    expect_store(14'd17, 16'h1234, "R2 sub");
    expect_store(14'd18, 16'h1D3B, "R2 xor");
    expect_store(14'd19, 16'hF0F0, "R3 copy+not");
    expect_store(14'd20, 16'h0F0F, "R3 shift right");
    expect_store(14'd21, 16'hF0F0, "R3 shift left");
    expect_store(14'd24, 16'h0F0F, "R4 load/addi signed");
    reset_and_run("prog1");

    // program 2: conditions, flags, call/return
    clear_imem();
    ldi(0, 4'd1, 16'h0030);
    ldi(2, 4'd2, 16'h0001);
    put(4,  e_reg(3'd1, 4'hF, 4'd2, 2'b00, 0, 0)); // r2=0, Z
    put(5,  e_reg(3'd7, 4'd1, 4'd2, 2'b01, 0, 0)); // if Z: store
    put(6,  e_reg(3'd7, 4'd1, 4'd2, 2'b10, 0, 0)); // if N: skipped
    put(7,  e_reg(3'd1, 4'hF, 4'd2, 2'b00, 0, 0)); // r2=FFFF, N
    put(8,  e_reg(3'd1, 4'd1, 4'd1, 2'b01, 0, 0)); // if Z: skipped
    put(9,  e_reg(3'd7, 4'd1, 4'd2, 2'b10, 0, 0)); // if N: store
    put(10, e_call(11'd2));
    put(11, e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(12, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 0));
    put(13, e_skip(8'd10));
    put(16, e_reg(3'd1, 4'd2, 4'd2, 2'b00, 0, 0));
    put(17, e_reg(3'd7, 4'd1, 4'd2, 2'b00, 0, 1)); // store + return
    put(24, e_call(11'd3));
    expect_store(14'd48, 16'h0000, "R5 zero-cond store");
    expect_store(14'd48, 16'hFFFF, "R5 neg-cond store, skipped addi");
    expect_store(14'd48, 16'h0001, "R6 store in callee");
    expect_store(14'd49, 16'h0001, "R6 return to caller");
    reset_and_run("prog2");

    // program 3: counted loop, load-immediate word not executed
    clear_imem();
    ldi(0, 4'd1, 16'h0040);
    ldi(2, 4'd3, 16'h0003);
    ldi(4, 4'd2, 16'h0000);
    put(6,  e_ctl(3'd0, 4'd0, 4'd3));              // loop r3 times
    put(7,  e_reg(3'd1, 4'd5, 4'd2, 2'b00, 0, 0));
    put(8,  e_reg(3'd1, 4'd1, 4'd1, 2'b00, 0, 0));
    put(9,  e_reg(3'd7, 4'd1, 4'd2, 2'b00, 1, 0)); // loop end
    ldi(10, 4'd4, 16'h0FE0);                       // word decodes as a store
    put(12, e_reg(3'd7, 4'd1, 4'd4, 2'b00, 0, 0));
    put(13, e_skip(8'd2));
    put(16, e_call(11'd2));
    expect_store(14'd65, 16'd5,    "R9 loop pass 1");
    expect_store(14'd66, 16'd10,   "R9 loop pass 2");
    expect_store(14'd67, 16'd15,   "R9 loop pass 3");
    expect_store(14'd67, 16'h0FE0, "R8 load-immediate");
    reset_and_run("prog3");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule